// File: doc/BRIEF.md
# Spike-Hardened Capacitive Touch Decision Channel

This block makes the touch decision for one capacitive sensing channel. Every accepted scan delivers one unsigned raw count. The block keeps a baseline for that count and reports the difference between the raw count and the baseline. It also decides whether the sensor is pressed. The decision is built to survive bursts of fast transient noise. Two kinds of damage are guarded against: short positive spikes that would fake a press, and short negative spikes that would release a held press or drag the baseline down.

The raw count arrives on a valid/ready stream input. The block never applies back-pressure: `s_ready` is tied high, and a sample counts as consumed in any cycle where `s_valid` is high. Nothing in the block changes in a cycle without `s_valid`. Thresholds and counts are plain configuration inputs, and software is expected to keep them steady. The outputs are plain status pins. They are registered, and each one reflects the accepted sample of the previous cycle.

Release takes its own run of quiet samples. Raw counts that sit far above the baseline are treated as noise. The baseline is reloaded downwards only after a long run below it, and that run limit is wider than 8 bits. A sensor that stays pressed too long is cleared by reloading the baseline.

Top module: `touch_detect`

## Requirements
- R1: While released, the sensor becomes pressed on the N-th consecutive accepted sample whose difference is above `cfg_finger_th` and not above `cfg_cutoff`, where N is `cfg_on_db` and 0 acts as 1. Any other sample restarts the run.
- R2: While pressed, the sensor is released on the M-th consecutive accepted sample whose difference is below `cfg_finger_th`, where M is `cfg_off_db` and 0 acts as 1. A sample at or above the threshold restarts the run.
- R3: A difference above `cfg_cutoff` never advances the press run and breaks it. A difference equal to `cfg_cutoff` still qualifies.
- R4: While released, the baseline is loaded with the raw count on the (L+1)-th consecutive sample whose raw count is below the baseline, where L is `cfg_lbr`. A run of L or fewer such samples leaves the baseline unchanged.
- R5: `cfg_lbr` is 12 bits wide, so dips longer than 255 samples can be tolerated. For example, L = 300 holds the baseline through 300 samples and reloads it on the 301st.
- R6: While pressed, the (A+1)-th consecutive pressed sample, where A is `cfg_ar_limit`, loads the baseline with that sample's raw count and releases the sensor. This autoreset wins over a release debounce that completes on the same sample.
- R7: While released, a raw count above the baseline by no more than `cfg_noise_th` raises the baseline by exactly 1. While pressed, the baseline changes only by autoreset.
- R8: `diff` equals the raw count minus the baseline held before the sample, and it saturates to 0 when the raw count is at or below that baseline. The first accepted sample after reset loads the baseline with its raw count and does not advance any debounce.
- R9: With `s_valid` low, `touch_on`, `baseline` and `diff` hold their values whatever `s_raw` does. `s_ready` is always 1.
- R10: After synchronous reset, `touch_on`, `baseline` and `diff` are 0 and all run counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Raw sample valid |
| s_ready | output | 1 | Always 1; the block takes every sample |
| s_raw | input | CW | Unsigned raw count |
| cfg_finger_th | input | CW | Press/release difference threshold |
| cfg_noise_th | input | CW | Largest difference the baseline tracks upwards |
| cfg_cutoff | input | CW | Largest difference treated as a finger |
| cfg_on_db | input | DBW | Consecutive samples needed to press |
| cfg_off_db | input | DBW | Consecutive samples needed to release |
| cfg_lbr | input | LBRW | Below-baseline samples tolerated before reload |
| cfg_ar_limit | input | ARW | Pressed samples tolerated before autoreset |
| touch_on | output | 1 | Sensor pressed |
| baseline | output | CW | Current baseline |
| diff | output | CW | Saturated difference of the last sample |

## Verification
The autoreset and the release debounce can both fire on the same sample. That case is provoked by setting the autoreset limit to 3 and the release count to 2. The sensor is pressed, held for two samples, and then sent two low samples, so the second low sample completes both at once. The expected outcome is a released sensor whose baseline equals that sample's raw count, because only the autoreset reloads the baseline. Release debounce alone would leave the old baseline in place. The cut-off boundary and the press run are also judged together: a difference one above the cut-off must leave the sensor released, and a difference equal to it must press the sensor at once.

// File: rtl/touch_pkg.sv
package touch_pkg;

  typedef enum logic {
    TS_RELEASED = 1'b0,
    TS_HELD     = 1'b1
  } touch_state_e;

  typedef struct packed {
    logic below;     // raw strictly under baseline
    logic above_th;  // difference over finger threshold
    logic under_th;  // difference under finger threshold
    logic over_cut;  // difference over upper cut-off
    logic in_noise;  // raw over baseline within noise band
  } sample_flags_t;

endpackage

// File: rtl/touch_classify.sv
module touch_classify
  import touch_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [CW-1:0]  raw,
  input  logic [CW-1:0]  base,
  input  logic [CW-1:0]  finger_th,
  input  logic [CW-1:0]  noise_th,
  input  logic [CW-1:0]  cutoff,
  output logic [CW-1:0]  diff,
  output sample_flags_t  flags
);

  logic rises;

  always_comb begin
    rises          = raw > base;
    diff           = rises ? (raw - base) : '0;
    flags.below    = raw < base;
    flags.above_th = diff > finger_th;
    flags.under_th = diff < finger_th;
    flags.over_cut = diff > cutoff;
    flags.in_noise = rises && (diff <= noise_th);
  end

endmodule

// File: rtl/touch_debounce.sv
module touch_debounce
  import touch_pkg::*;
#(
  parameter int DBW = 4,
  parameter int ARW = 20
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           valid,
  input  logic           prime,
  input  sample_flags_t  flags,
  input  logic [DBW-1:0] on_db,
  input  logic [DBW-1:0] off_db,
  input  logic [ARW-1:0] ar_limit,
  output logic           touch,
  output logic           ar_fire
);

  touch_state_e   state_q;
  logic [DBW-1:0] on_cnt_q;
  logic [DBW-1:0] off_cnt_q;
  logic [ARW-1:0] ar_cnt_q;
  logic [DBW:0]   on_next;
  logic [DBW:0]   off_next;
  logic           take;
  logic           press_ok;

  assign take     = valid && !prime;
  assign on_next  = {1'b0, on_cnt_q} + 1'b1;
  assign off_next = {1'b0, off_cnt_q} + 1'b1;
  assign press_ok = flags.above_th && !flags.over_cut;
  assign ar_fire  = take && (state_q == TS_HELD) && (ar_cnt_q >= ar_limit);
  assign touch    = (state_q == TS_HELD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= TS_RELEASED;
      on_cnt_q  <= '0;
      off_cnt_q <= '0;
      ar_cnt_q  <= '0;
    end else if (take) begin
      case (state_q)
        TS_RELEASED: begin
          off_cnt_q <= '0;
          ar_cnt_q  <= '0;
          if (press_ok) begin
            if (on_next >= {1'b0, on_db}) begin
              state_q  <= TS_HELD;
              on_cnt_q <= '0;
            end else begin
              on_cnt_q <= on_next[DBW-1:0];
            end
          end else begin
            on_cnt_q <= '0;
          end
        end
        default: begin
          on_cnt_q <= '0;
          if (ar_fire) begin
            state_q   <= TS_RELEASED;
            off_cnt_q <= '0;
            ar_cnt_q  <= '0;
          end else begin
            ar_cnt_q <= ar_cnt_q + 1'b1;
            if (flags.under_th) begin
              if (off_next >= {1'b0, off_db}) begin
                state_q   <= TS_RELEASED;
                off_cnt_q <= '0;
                ar_cnt_q  <= '0;
              end else begin
                off_cnt_q <= off_next[DBW-1:0];
              end
            end else begin
              off_cnt_q <= '0;
            end
          end
        end
      endcase
    end
  end

  // R3: a press never follows an over-range sample
  assert_no_press_over_cut_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(touch) |-> $past(valid && !prime && !flags.over_cut && flags.above_th));

  // R6: autoreset always releases the sensor
  assert_autoreset_releases_R6: assert property (@(posedge clk) disable iff (rst)
    ar_fire |=> !touch);

  // R9: press state holds without a sample
  assert_touch_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(touch));

endmodule

// File: rtl/touch_baseline.sv
module touch_baseline
  import touch_pkg::*;
#(
  parameter int CW   = 16,
  parameter int LBRW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid,
  input  logic [CW-1:0]   raw,
  input  sample_flags_t   flags,
  input  logic            touch,
  input  logic            ar_fire,
  input  logic [LBRW-1:0] lbr_limit,
  output logic [CW-1:0]   base,
  output logic            prime
);

  logic [CW-1:0]   base_q;
  logic [LBRW-1:0] lbr_cnt_q;
  logic            init_q;

  assign base  = base_q;
  assign prime = !init_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      lbr_cnt_q <= '0;
      init_q    <= 1'b0;
    end else if (valid) begin
      if (!init_q) begin
        base_q    <= raw;
        lbr_cnt_q <= '0;
        init_q    <= 1'b1;
      end else if (ar_fire) begin
        base_q    <= raw;
        lbr_cnt_q <= '0;
      end else if (touch) begin
        lbr_cnt_q <= '0;
      end else if (flags.below) begin
        if (lbr_cnt_q >= lbr_limit) begin
          base_q    <= raw;
          lbr_cnt_q <= '0;
        end else begin
          lbr_cnt_q <= lbr_cnt_q + 1'b1;
        end
      end else begin
        lbr_cnt_q <= '0;
        if (flags.in_noise) base_q <= base_q + 1'b1;
      end
    end
  end

  // R4: a dip still inside the tolerated run leaves the baseline alone
  assert_short_dip_holds_R4: assert property (@(posedge clk) disable iff (rst)
    valid && init_q && !touch && flags.below && (lbr_cnt_q < lbr_limit) |=> $stable(base_q));

  // R7: baseline frozen while pressed unless autoreset
  assert_frozen_when_held_R7: assert property (@(posedge clk) disable iff (rst)
    valid && init_q && touch && !ar_fire |=> $stable(base_q));

  // R9: no sample, no baseline change
  assert_base_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(base_q));

endmodule

// File: rtl/touch_detect.sv
module touch_detect
  import touch_pkg::*;
#(
  parameter int CW   = 16,
  parameter int DBW  = 4,
  parameter int LBRW = 12,
  parameter int ARW  = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [CW-1:0]   s_raw,
  input  logic [CW-1:0]   cfg_finger_th,
  input  logic [CW-1:0]   cfg_noise_th,
  input  logic [CW-1:0]   cfg_cutoff,
  input  logic [DBW-1:0]  cfg_on_db,
  input  logic [DBW-1:0]  cfg_off_db,
  input  logic [LBRW-1:0] cfg_lbr,
  input  logic [ARW-1:0]  cfg_ar_limit,
  output logic            touch_on,
  output logic [CW-1:0]   baseline,
  output logic [CW-1:0]   diff
);

  sample_flags_t flags;
  logic [CW-1:0] diff_c;
  logic [CW-1:0] diff_q;
  logic [CW-1:0] base_w;
  logic          prime;
  logic          held;
  logic          ar_fire;

  assign s_ready  = 1'b1;
  assign touch_on = held;
  assign baseline = base_w;
  assign diff     = diff_q;

  touch_classify #(.CW(CW)) u_classify (
    .raw       (s_raw),
    .base      (base_w),
    .finger_th (cfg_finger_th),
    .noise_th  (cfg_noise_th),
    .cutoff    (cfg_cutoff),
    .diff      (diff_c),
    .flags     (flags)
  );

  touch_debounce #(.DBW(DBW), .ARW(ARW)) u_debounce (
    .clk      (clk),
    .rst      (rst),
    .valid    (s_valid),
    .prime    (prime),
    .flags    (flags),
    .on_db    (cfg_on_db),
    .off_db   (cfg_off_db),
    .ar_limit (cfg_ar_limit),
    .touch    (held),
    .ar_fire  (ar_fire)
  );

  touch_baseline #(.CW(CW), .LBRW(LBRW)) u_baseline (
    .clk       (clk),
    .rst       (rst),
    .valid     (s_valid),
    .raw       (s_raw),
    .flags     (flags),
    .touch     (held),
    .ar_fire   (ar_fire),
    .lbr_limit (cfg_lbr),
    .base      (base_w),
    .prime     (prime)
  );

  always_ff @(posedge clk) begin
    if (rst)          diff_q <= '0;
    else if (s_valid) diff_q <= diff_c;
  end

  // R8: raw at or under baseline reports zero difference
  assert_diff_saturates_R8: assert property (@(posedge clk) disable iff (rst)
    s_valid && (s_raw <= baseline) |=> diff == '0);

  // R6: autoreset loads the sample into the baseline
  assert_autoreset_loads_R6: assert property (@(posedge clk) disable iff (rst)
    ar_fire |=> baseline == $past(s_raw));

  // R9: difference holds without a sample
  assert_diff_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !s_valid |=> $stable(diff));

endmodule

// File: tb/touch_detect_tb.sv
module touch_detect_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int NV = 20;

  typedef struct packed {
    logic [15:0] raw;
    logic        t;
    logic [15:0] base;
    logic [15:0] dif;
  } vec_t;

  // finger 100, noise 20, cutoff 500, on 3, off 2, lbr 10
  localparam vec_t VEC [NV] = '{
    '{16'd1000, 1'b0, 16'd1000, 16'd1000},  // R8 first sample loads
    '{16'd1010, 1'b0, 16'd1001, 16'd10},    // R7 step up
    '{16'd1001, 1'b0, 16'd1001, 16'd0},
    '{16'd1200, 1'b0, 16'd1001, 16'd199},   // R1 run 1
    '{16'd1200, 1'b0, 16'd1001, 16'd199},   // R1 run 2
    '{16'd1700, 1'b0, 16'd1001, 16'd699},   // R3 breaks run
    '{16'd1200, 1'b0, 16'd1001, 16'd199},
    '{16'd1200, 1'b0, 16'd1001, 16'd199},
    '{16'd1200, 1'b1, 16'd1001, 16'd199},   // R1 pressed on 3rd
    '{16'd1050, 1'b1, 16'd1001, 16'd49},    // R2 off run 1
    '{16'd1200, 1'b1, 16'd1001, 16'd199},   // R2 run broken
    '{16'd1050, 1'b1, 16'd1001, 16'd49},
    '{16'd900,  1'b0, 16'd1001, 16'd0},     // R2 released, R8 saturate
    '{16'd1011, 1'b0, 16'd1002, 16'd10},
    '{16'd900,  1'b0, 16'd1002, 16'd0},     // R4 short dip
    '{16'd900,  1'b0, 16'd1002, 16'd0},
    '{16'd900,  1'b0, 16'd1002, 16'd0},
    '{16'd900,  1'b0, 16'd1002, 16'd0},
    '{16'd900,  1'b0, 16'd1002, 16'd0},
    '{16'd1002, 1'b0, 16'd1002, 16'd0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [CW-1:0] s_raw = '0;
  logic [CW-1:0] cfg_finger_th, cfg_noise_th, cfg_cutoff;
  logic [3:0]    cfg_on_db, cfg_off_db;
  logic [11:0]   cfg_lbr;
  logic [19:0]   cfg_ar_limit;
  logic          touch_on;
  logic [CW-1:0] baseline, diff;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  touch_detect u_dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_raw(s_raw),
    .cfg_finger_th(cfg_finger_th), .cfg_noise_th(cfg_noise_th), .cfg_cutoff(cfg_cutoff),
    .cfg_on_db(cfg_on_db), .cfg_off_db(cfg_off_db), .cfg_lbr(cfg_lbr),
    .cfg_ar_limit(cfg_ar_limit), .touch_on(touch_on), .baseline(baseline), .diff(diff)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic defaults();
    cfg_finger_th = 16'd100;
    cfg_noise_th  = 16'd20;
    cfg_cutoff    = 16'd500;
    cfg_on_db     = 4'd3;
    cfg_off_db    = 4'd2;
    cfg_lbr       = 12'd10;
    cfg_ar_limit  = 20'd100000;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    s_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(input logic [CW-1:0] r);
    @(negedge clk);
    s_raw = r;
    s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic send_n(input logic [CW-1:0] r, input int n);
    for (int i = 0; i < n; i++) send(r);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    defaults();
    do_reset();
    @(negedge clk);
    chk("R10 touch after reset", touch_on, 0);
    chk("R10 baseline after reset", baseline, 0);
    chk("R10 diff after reset", diff, 0);
    chk("R9 ready", s_ready, 1);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i].raw);
      chk($sformatf("R1 R2 R7 R8 vec %0d touch", i), touch_on, VEC[i].t);
      chk($sformatf("R4 R7 vec %0d baseline", i), baseline, VEC[i].base);
      chk($sformatf("R8 vec %0d diff", i), diff, VEC[i].dif);
    end

    // R9: idle cycles with changing raw
    @(negedge clk);
    s_raw = 16'd5000;
    repeat (5) @(negedge clk);
    chk("R9 idle touch", touch_on, 0);
    chk("R9 idle baseline", baseline, 1002);
    chk("R9 idle diff", diff, 0);

    // R4: lbr 10 with a 20-sample dip follows the dip
    defaults();
    do_reset();
    send(16'd1000);
    send_n(16'd800, 10);
    chk("R4 lbr10 held after 10", baseline, 1000);
    send(16'd800);
    chk("R4 lbr10 reload on 11th", baseline, 800);
    send_n(16'd800, 9);
    send_n(16'd1000, 3);
    chk("R4 lbr10 false press on recovery", touch_on, 1);

    // R4: lbr 30 with the same dip holds
    defaults();
    cfg_lbr = 12'd30;
    do_reset();
    send(16'd1000);
    send_n(16'd800, 20);
    chk("R4 lbr30 baseline held", baseline, 1000);
    send_n(16'd1000, 3);
    chk("R4 lbr30 no false press", touch_on, 0);

    // R5: limit above 255
    defaults();
    cfg_lbr = 12'd300;
    do_reset();
    send(16'd1000);
    send_n(16'd800, 300);
    chk("R5 lbr300 held after 300", baseline, 1000);
    send(16'd800);
    chk("R5 lbr300 reload on 301st", baseline, 800);

    // R3: cut-off boundary
    defaults();
    cfg_on_db = 4'd1;
    do_reset();
    send(16'd1000);
    send(16'd1501);
    chk("R3 over cutoff no press", touch_on, 0);
    chk("R3 over cutoff baseline", baseline, 1000);
    send(16'd1500);
    chk("R3 equal cutoff presses", touch_on, 1);

    // R7: frozen while pressed inside noise band
    defaults();
    cfg_on_db = 4'd1;
    cfg_off_db = 4'd3;
    do_reset();
    send(16'd1000);
    send(16'd1300);
    send(16'd1010);
    chk("R7 frozen touch", touch_on, 1);
    chk("R7 frozen baseline", baseline, 1000);

    // R6: autoreset after 5 pressed samples
    defaults();
    cfg_on_db = 4'd1;
    cfg_off_db = 4'd3;
    cfg_ar_limit = 20'd5;
    do_reset();
    send(16'd1000);
    send(16'd1300);
    send_n(16'd1300, 5);
    chk("R6 still pressed after limit", touch_on, 1);
    chk("R6 baseline before autoreset", baseline, 1000);
    send(16'd1300);
    chk("R6 autoreset releases", touch_on, 0);
    chk("R6 autoreset loads raw", baseline, 1300);
    chk("R6 diff against old baseline", diff, 300);
    send(16'd1300);
    chk("R6 diff after autoreset", diff, 0);

    // R6: autoreset and release debounce on the same sample
    defaults();
    cfg_on_db = 4'd1;
    cfg_off_db = 4'd2;
    cfg_ar_limit = 20'd3;
    do_reset();
    send(16'd1000);
    send(16'd1300);
    send_n(16'd1300, 2);
    send(16'd1050);
    chk("R6 coincide pre touch", touch_on, 1);
    send(16'd1050);
    chk("R6 coincide released", touch_on, 0);
    chk("R6 coincide autoreset wins", baseline, 1050);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule